// File: doc/BRIEF.md
# Graphics Aperture Address Translator

This block sits on the inbound path of a graphics port. Each request carries a 40-bit address. The block sorts every address into one of three regions, using range registers held in configuration space. The first region is the graphics aperture. An aperture address is remapped through a page table held on chip to a 36-bit physical address. The second region is system memory (DRAM). A DRAM address is already physical, so it passes through. The third region is the I/O bridge (PCI). A PCI address passes through and is tagged for that destination. An address that falls in no region is returned as an error.

The aperture base register acts like a standard PCI base address register. The aperture size is fixed by the PAGE_IDX_W parameter. Software learns that size by writing all ones to the register and reading it back. The aperture may sit anywhere in the 40-bit space, including above 4 GB. The page table holds 4 KB pages. Software can rewrite table entries at any time, and new requests see the new mapping. Requests and responses each use a valid/ready handshake, with one register stage in between.

Top module: `gfx_aperture_xlate`

## Requirements
- R1: After reset, rsp_valid is 0, req_ready is 1, the overlap status (select 6, bit 0) reads 0, and the aperture base (select 0) reads 0.
- R2: The aperture base register is written and read at select 0. It keeps bits [39:12+PAGE_IDX_W] and reads zeros below them. Writing all ones therefore reads back as 40'hFF_FFFF_0000 when PAGE_IDX_W=4.
- R3: An address whose bits [39:12+PAGE_IDX_W] equal the aperture base is an aperture hit. Bits [12+PAGE_IDX_W-1:12] of the address index the table. For a valid entry, rsp_addr is {entry PPN, addr[11:0]}, rsp_region is 0 and rsp_err is 0.
- R4: A table entry is written at select 5 with cfg_idx as its index. In the write data, bit 24 is the valid bit and bits [23:0] are the page number. An aperture hit on an entry whose valid bit is 0 gives rsp_err=1, rsp_region=0 and rsp_addr=0.
- R5: DRAM range: low bound at select 1, exclusive top at select 2. An address in this range, and in no higher-priority region, gives rsp_region=1, rsp_err=0 and rsp_addr=addr[35:0].
- R6: PCI range: low bound at select 3, exclusive top at select 4. An address in this range, and not in the aperture, gives rsp_region=2, rsp_err=0 and rsp_addr=addr[35:0].
- R7: An address in no region gives rsp_region=3, rsp_err=1 and rsp_addr=0.
- R8: When regions overlap, the aperture wins over PCI, and PCI wins over DRAM. An accepted request that hits more than one region sets the sticky overlap bit (select 6, bit 0). Only a write to select 6 clears it.
- R9: A request accepted at a clock edge shows its response with rsp_valid=1 right after that same edge.
- R10: While rsp_valid=1 and rsp_ready=0, req_ready is 0 and the response outputs hold steady.
- R11: A table entry rewritten at run time changes the translation of requests that follow.
- R12: An aperture placed above 4 GB (for example at 40'h80_0000_0000) translates correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select (0 aperture base, 1/2 DRAM low/top, 3/4 PCI low/top, 5 table, 6 status) |
| cfg_idx | input | PAGE_IDX_W | Table entry index for select 5 |
| cfg_wdata | input | 40 | Configuration write data |
| cfg_rdata | output | 40 | Combinational read of the selected register |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_addr | input | 40 | Request address |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_addr | output | 36 | Physical address, 0 on error |
| rsp_region | output | 2 | 0 aperture, 1 DRAM, 2 PCI, 3 unmapped |
| rsp_err | output | 1 | Invalid entry or unmapped address |

## Verification
The bench drives inputs on the falling edge. It expects each response exactly one rising edge after acceptance, so it samples rsp_* on the next falling edge. Configuration writes take effect at the rising edge that follows the strobe. Reads are combinational and are sampled shortly after cfg_sel settles. In the back-pressure scenario the bench counts edges: it confirms the response stays unchanged across a stalled edge. It then confirms the queued request appears one edge after rsp_ready rises.

// File: rtl/gfx_aperture_xlate.sv
module gfx_aperture_xlate #(
  parameter int ADDR_W     = 40,
  parameter int PHYS_W     = 36,
  parameter int PAGE_IDX_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [2:0]            cfg_sel,
  input  logic [PAGE_IDX_W-1:0] cfg_idx,
  input  logic [ADDR_W-1:0]     cfg_wdata,
  output logic [ADDR_W-1:0]     cfg_rdata,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ADDR_W-1:0]     req_addr,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [PHYS_W-1:0]     rsp_addr,
  output logic [1:0]            rsp_region,
  output logic                  rsp_err
);
  localparam int PAGES    = 1 << PAGE_IDX_W;
  localparam int APER_LSB = 12 + PAGE_IDX_W;
  localparam int PPN_W    = PHYS_W - 12;

  logic [ADDR_W-1:APER_LSB] aper_base;
  logic [ADDR_W-1:0]        dram_lo, dram_hi, pci_lo, pci_hi;
  logic [PPN_W:0]           tbl [PAGES];
  logic                     ovl;

  logic              hit_ap, hit_dram, hit_pci, accept;
  logic [PPN_W:0]    ent;
  logic [PHYS_W-1:0] n_addr;
  logic [1:0]        n_region;
  logic              n_err;

  assign hit_ap   = req_addr[ADDR_W-1:APER_LSB] == aper_base;
  assign hit_pci  = (req_addr >= pci_lo) && (req_addr < pci_hi);
  assign hit_dram = (req_addr >= dram_lo) && (req_addr < dram_hi);
  assign ent      = tbl[req_addr[APER_LSB-1:12]];
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_comb begin
    n_addr   = '0;
    n_region = 2'd3;
    n_err    = 1'b1;
    if (hit_ap) begin
      n_region = 2'd0;
      n_err    = !ent[PPN_W];
      if (ent[PPN_W]) n_addr = {ent[PPN_W-1:0], req_addr[11:0]};
    end else if (hit_pci) begin
      n_region = 2'd2;
      n_err    = 1'b0;
      n_addr   = req_addr[PHYS_W-1:0];
    end else if (hit_dram) begin
      n_region = 2'd1;
      n_err    = 1'b0;
      n_addr   = req_addr[PHYS_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aper_base <= '0;
      dram_lo   <= '0;
      dram_hi   <= '0;
      pci_lo    <= '0;
      pci_hi    <= '0;
      for (int i = 0; i < PAGES; i++) tbl[i] <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        3'd0: aper_base <= cfg_wdata[ADDR_W-1:APER_LSB];
        3'd1: dram_lo   <= cfg_wdata;
        3'd2: dram_hi   <= cfg_wdata;
        3'd3: pci_lo    <= cfg_wdata;
        3'd4: pci_hi    <= cfg_wdata;
        3'd5: tbl[cfg_idx] <= cfg_wdata[PPN_W:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ovl <= 1'b0;
    else if (cfg_we && cfg_sel == 3'd6) ovl <= 1'b0;
    else if (accept && ({1'b0, hit_ap} + {1'b0, hit_pci} + {1'b0, hit_dram} > 2'd1)) ovl <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_addr   <= '0;
      rsp_region <= '0;
      rsp_err    <= 1'b0;
    end else if (accept) begin
      rsp_valid  <= 1'b1;
      rsp_addr   <= n_addr;
      rsp_region <= n_region;
      rsp_err    <= n_err;
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end

  always_comb begin
    case (cfg_sel)
      3'd0:    cfg_rdata = {aper_base, {APER_LSB{1'b0}}};
      3'd1:    cfg_rdata = dram_lo;
      3'd2:    cfg_rdata = dram_hi;
      3'd3:    cfg_rdata = pci_lo;
      3'd4:    cfg_rdata = pci_hi;
      3'd5:    cfg_rdata = {{(ADDR_W-PPN_W-1){1'b0}}, tbl[cfg_idx]};
      3'd6:    cfg_rdata = {{(ADDR_W-1){1'b0}}, ovl};
      default: cfg_rdata = '0;
    endcase
  end

  AST_ONE_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid); // R9
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_region) && $stable(rsp_err)); // R10
  AST_NO_READY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready); // R10
  AST_ERR_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_addr == '0); // R4
  AST_UNMAPPED_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_region == 2'd3 |-> rsp_err); // R7
  AST_OVL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovl && !(cfg_we && cfg_sel == 3'd6) |=> ovl); // R8
endmodule

// File: tb/gfx_aperture_xlate_bench.sv
`timescale 1ns/1ps
module gfx_aperture_xlate_bench;
  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0;
  logic [2:0]  cfg_sel = 0;
  logic [3:0]  cfg_idx = 0;
  logic [39:0] cfg_wdata = 0, cfg_rdata;
  logic        req_valid = 0, req_ready, rsp_valid, rsp_ready = 1, rsp_err;
  logic [39:0] req_addr = 0;
  logic [35:0] rsp_addr;
  logic [1:0]  rsp_region;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  gfx_aperture_xlate u_gfx_aperture_xlate (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] sel, logic [3:0] idx, logic [39:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rd(logic [2:0] sel, logic [3:0] idx, output logic [39:0] d);
    @(negedge clk);
    cfg_sel = sel; cfg_idx = idx;
    #1 d = cfg_rdata;
  endtask

  task automatic send(string tag, logic [39:0] a, logic [35:0] ea, logic [1:0] er, logic ee);
    @(negedge clk);
    req_valid = 1; req_addr = a; rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk({tag, " valid"}, rsp_valid, 1);
    chk({tag, " addr"}, rsp_addr, ea);
    chk({tag, " region"}, rsp_region, er);
    chk({tag, " err"}, rsp_err, ee);
  endtask

  task automatic t_reset();
    logic [39:0] d;
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 req_ready", req_ready, 1);
    rd(3'd6, 0, d); chk("R1 status", d, 0);
    rd(3'd0, 0, d); chk("R1 base", d, 0);
  endtask

  task automatic t_bar();
    logic [39:0] d;
    wr(3'd0, 0, '1);
    rd(3'd0, 0, d); chk("R2 probe", d, 40'hFF_FFFF_0000);
    wr(3'd0, 0, 40'h80_0000_0000);
    rd(3'd0, 0, d); chk("R2 base", d, 40'h80_0000_0000);
  endtask

  task automatic t_setup();
    wr(3'd1, 0, 40'h0);
    wr(3'd2, 0, 40'h1_0000_0000);
    wr(3'd3, 0, 40'h1_0000_0000);
    wr(3'd4, 0, 40'h1_1000_0000);
    wr(3'd5, 4'd3, 40'h1_0ABCDE);
    wr(3'd5, 4'd5, 40'h0_012345);
  endtask

  task automatic t_regions();
    logic [39:0] d;
    send("R3 R12 aperture", 40'h80_0000_3123, 36'h0ABCDE123, 2'd0, 0);
    send("R4 invalid", 40'h80_0000_5FFF, 36'h0, 2'd0, 1);
    send("R5 dram", 40'h0_1234_5678, 36'h0_1234_5678, 2'd1, 0);
    send("R6 pci", 40'h1_0000_0040, 36'h1_0000_0040, 2'd2, 0);
    send("R7 unmapped", 40'h2_0000_0000, 36'h0, 2'd3, 1);
    rd(3'd6, 0, d); chk("R8 no overlap", d, 0);
  endtask

  task automatic t_runtime();
    wr(3'd5, 4'd5, 40'h1_00FEED);
    send("R11 updated", 40'h80_0000_5ABC, 36'h00FEEDABC, 2'd0, 0);
    wr(3'd5, 4'd3, 40'h0_0ABCDE);
    send("R11 invalidated", 40'h80_0000_3123, 36'h0, 2'd0, 1);
  endtask

  task automatic t_overlap();
    logic [39:0] d;
    wr(3'd3, 0, 40'h8000_0000);
    wr(3'd4, 0, 40'h9000_0000);
    send("R8 pci over dram", 40'h8000_1000, 36'h8000_1000, 2'd2, 0);
    rd(3'd6, 0, d); chk("R8 sticky set", d, 1);
    send("R8 still sticky", 40'h0_0000_1000, 36'h0_0000_1000, 2'd1, 0);
    rd(3'd6, 0, d); chk("R8 sticky kept", d, 1);
    wr(3'd0, 0, 40'h8000_0000);
    send("R8 aperture first", 40'h8000_5001, 36'h00FEED001, 2'd0, 0);
    wr(3'd6, 0, 0);
    rd(3'd6, 0, d); chk("R8 cleared", d, 0);
  endtask

  task automatic t_stall();
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_addr = 40'h0_0000_2000;
    @(negedge clk);
    chk("R9 valid", rsp_valid, 1);
    chk("R10 req_ready low", req_ready, 0);
    req_addr = 40'h0_0000_3000;
    @(negedge clk);
    chk("R10 held addr", rsp_addr, 36'h0_0000_2000);
    chk("R10 held valid", rsp_valid, 1);
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk("R10 next addr", rsp_addr, 36'h0_0000_3000);
    chk("R10 next valid", rsp_valid, 1);
    @(negedge clk);
    chk("R9 drained", rsp_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_bar();
    t_setup();
    t_regions();
    t_runtime();
    t_overlap();
    t_stall();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule